// File: doc/BRIEF.md
# Register Producer-Tag Table

This block is the register file of an out-of-order issue stage in which every architectural register holds a data value and an optional producer tag. The tag names the reservation station that will supply the register's next value. When an instruction issues, the table answers two source lookups. Each lookup returns either a ready value or the tag that the waiting station must watch for. In the same cycle the table records the issuing station's tag against the destination register.

Completed results arrive on the common data bus as a tag plus a value. A register accepts a broadcast only while its own tag still names that broadcaster. This keeps write-after-write ordering correct when an older producer finishes after a younger one. A separate load port writes initial register contents and marks them ready.

Top module: `rtag_table`

## Requirements
- R1: After synchronous reset every register reads ready with value 0.
- R2: A load (`ld_we`) writes `ld_data` into register `ld_idx` and clears its producer tag. From the next cycle the register reads ready with that value, even if it was waiting on a producer.
- R3: A read of a register with no producer tag returns ready=1 and the stored value on the same cycle's outputs.
- R4: An issue (`iss_we`) sets register `iss_dst` to wait on `iss_tag` from the next cycle. It replaces any older pending tag. A waiting register reads ready=0 and its `*_tag` output equals the pending tag.
- R5: A bus broadcast whose tag equals a waiting register's tag writes the bus value into that register and makes it ready in the next cycle.
- R6: A broadcast whose tag differs from a register's pending tag leaves that register's value, tag and ready state unchanged.
- R7: A read of a waiting register in the cycle that its matching broadcast is on the bus returns ready=1 and the bus value combinationally.
- R8: If an issue renames a register in the same cycle that its old producer broadcasts, the register takes the new tag and stays not ready. Its stored value still becomes the broadcast value.
- R9: A read of the register being renamed in the same cycle returns the state held before that rename.
- R10: The two read ports are independent: each returns the state of its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Initial-value load strobe |
| ld_idx | input | 3 | Register index to load |
| ld_data | input | 32 | Value to load |
| iss_we | input | 1 | Issue strobe: rename the destination |
| iss_dst | input | 3 | Destination register of the issuing instruction |
| iss_tag | input | 3 | Station tag of the issuing instruction |
| bus_valid | input | 1 | Common data bus broadcast valid |
| bus_tag | input | 3 | Tag of the broadcasting station |
| bus_data | input | 32 | Broadcast result value |
| rda_idx | input | 3 | Read port A register index |
| rda_ready | output | 1 | Port A: value is valid |
| rda_value | output | 32 | Port A: register or forwarded value |
| rda_tag | output | 3 | Port A: producer tag to wait on |
| rdb_idx | input | 3 | Read port B register index |
| rdb_ready | output | 1 | Port B: value is valid |
| rdb_value | output | 32 | Port B: register or forwarded value |
| rdb_tag | output | 3 | Port B: producer tag to wait on |

## Verification
The assertions take for granted that a load and an issue never target the same register in the same cycle. The stimulus keeps loads in their own cycles. The forwarding and clearing properties also assume that a tag on the bus belongs to a single in-flight station. Every scenario therefore allocates distinct tags to pending producers, and it broadcasts stale tags only after the register has been renamed away from them.

// File: rtl/rtag_pkg.sv
package rtag_pkg;
    localparam int unsigned NUM_REGS = 8;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned TAG_W    = 3;
    localparam int unsigned IDX_W    = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic busy;
        tag_t tag;
    } producer_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t data;
    } bcast_t;

    function automatic logic bus_hits(input producer_t p, input bcast_t b);
        return p.busy && b.valid && (b.tag == p.tag);
    endfunction
endpackage

// File: rtl/rtag_entry.sv
module rtag_entry
    import rtag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ld_hit,
    input  word_t     ld_data,
    input  logic      ren_hit,
    input  tag_t      ren_tag,
    input  bcast_t    bus,
    output word_t     value,
    output producer_t prod
);
    logic match;
    assign match = bus_hits(prod, bus);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            prod  <= '0;
        end else begin
            if (ld_hit)      value <= ld_data;
            else if (match)  value <= bus.data;

            if (ren_hit)              prod <= '{busy: 1'b1, tag: ren_tag};
            else if (ld_hit || match) prod <= '0;
        end
    end

    AST_LOAD_READY: assert property (@(posedge clk) disable iff (rst)
        (ld_hit && !ren_hit) |=> (!prod.busy && value == $past(ld_data))); // R2
    AST_RENAME_TAG: assert property (@(posedge clk) disable iff (rst)
        ren_hit |=> (prod.busy && prod.tag == $past(ren_tag))); // R4
    AST_MATCH_WRITES: assert property (@(posedge clk) disable iff (rst)
        (match && !ld_hit) |=> (value == $past(bus.data))); // R5
    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (match && !ren_hit) |=> !prod.busy); // R5
    AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (prod.busy && bus.valid && bus.tag != prod.tag && !ld_hit && !ren_hit)
        |=> ($stable(value) && $stable(prod))); // R6
    AST_RENAME_WINS: assert property (@(posedge clk) disable iff (rst)
        (match && ren_hit && !ld_hit)
        |=> (prod.busy && value == $past(bus.data))); // R8
endmodule

// File: rtl/rtag_read_port.sv
module rtag_read_port
    import rtag_pkg::*;
#(
    parameter int unsigned N = NUM_REGS
) (
    input  logic      clk,
    input  logic      rst,
    input  idx_t      idx,
    input  word_t     values [N],
    input  producer_t prods  [N],
    input  bcast_t    bus,
    output logic      ready,
    output word_t     value,
    output tag_t      tag
);
    producer_t sel_p;
    word_t     sel_v;
    logic      fwd;

    always_comb begin
        sel_p = prods[idx];
        sel_v = values[idx];
        fwd   = bus_hits(sel_p, bus);
        ready = !sel_p.busy || fwd;
        value = fwd ? bus.data : sel_v;
        tag   = sel_p.tag;
    end

    AST_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (prods[idx].busy && bus.valid && bus.tag == prods[idx].tag)
        |-> (ready && value == bus.data)); // R7
    AST_WAIT_TAG: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (prods[idx].busy && tag == prods[idx].tag)); // R4
    AST_IDLE_VALUE: assert property (@(posedge clk) disable iff (rst)
        !prods[idx].busy |-> (ready && value == values[idx])); // R3
endmodule

// File: rtl/rtag_table.sv
module rtag_table
    import rtag_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_we,
    input  logic [IDX_W-1:0]    ld_idx,
    input  logic [DATA_W-1:0]   ld_data,
    input  logic                iss_we,
    input  logic [IDX_W-1:0]    iss_dst,
    input  logic [TAG_W-1:0]    iss_tag,
    input  logic                bus_valid,
    input  logic [TAG_W-1:0]    bus_tag,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic [IDX_W-1:0]    rda_idx,
    output logic                rda_ready,
    output logic [DATA_W-1:0]   rda_value,
    output logic [TAG_W-1:0]    rda_tag,
    input  logic [IDX_W-1:0]    rdb_idx,
    output logic                rdb_ready,
    output logic [DATA_W-1:0]   rdb_value,
    output logic [TAG_W-1:0]    rdb_tag
);
    localparam int unsigned NPORTS = 2;

    bcast_t    bus;
    word_t     values [NUM_REGS];
    producer_t prods  [NUM_REGS];
    idx_t      rd_idx   [NPORTS];
    logic      rd_ready [NPORTS];
    word_t     rd_value [NPORTS];
    tag_t      rd_tag   [NPORTS];

    assign bus = '{valid: bus_valid, tag: bus_tag, data: bus_data};

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        rtag_entry u_entry (
            .clk     (clk),
            .rst     (rst),
            .ld_hit  (ld_we && ld_idx == idx_t'(i)),
            .ld_data (ld_data),
            .ren_hit (iss_we && iss_dst == idx_t'(i)),
            .ren_tag (iss_tag),
            .bus     (bus),
            .value   (values[i]),
            .prod    (prods[i])
        );
    end

    assign rd_idx[0] = rda_idx;
    assign rd_idx[1] = rdb_idx;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rtag_read_port #(.N(NUM_REGS)) u_port (
            .clk    (clk),
            .rst    (rst),
            .idx    (rd_idx[p]),
            .values (values),
            .prods  (prods),
            .bus    (bus),
            .ready  (rd_ready[p]),
            .value  (rd_value[p]),
            .tag    (rd_tag[p])
        );
    end

    assign rda_ready = rd_ready[0];
    assign rda_value = rd_value[0];
    assign rda_tag   = rd_tag[0];
    assign rdb_ready = rd_ready[1];
    assign rdb_value = rd_value[1];
    assign rdb_tag   = rd_tag[1];

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        (rda_idx == rdb_idx) |-> (rda_ready == rdb_ready && rda_value == rdb_value)); // R10
endmodule

// File: tb/tb_rtag_table.sv
module tb_rtag_table;
    import rtag_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic ld_we, iss_we, bus_valid;
    idx_t ld_idx, iss_dst, rda_idx, rdb_idx;
    word_t ld_data, bus_data, rda_value, rdb_value;
    tag_t iss_tag, bus_tag, rda_tag, rdb_tag;
    logic rda_ready, rdb_ready;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtag_table dut (
        .clk(clk), .rst(rst),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .iss_we(iss_we), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .rda_idx(rda_idx), .rda_ready(rda_ready), .rda_value(rda_value), .rda_tag(rda_tag),
        .rdb_idx(rdb_idx), .rdb_ready(rdb_ready), .rdb_value(rdb_value), .rdb_tag(rdb_tag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // port A state check: ready, value, and tag when waiting
    task automatic expect_a(input string req, input bit rdy, input word_t val, input tag_t tg);
        check(rda_ready == rdy, req, rda_ready, rdy);
        check(rda_value == val, req, rda_value, val);
        if (!rdy) check(rda_tag == tg, req, rda_tag, tg);
    endtask

    // commit current inputs at the next edge, then clear strobes
    task automatic tick();
        @(posedge clk);
        #1;
        ld_we = 0; iss_we = 0; bus_valid = 0;
        @(negedge clk);
    endtask

    task automatic load(input idx_t r, input word_t d);
        ld_we = 1; ld_idx = r; ld_data = d;
        tick();
    endtask

    task automatic t_reset();
        rda_idx = 0; rdb_idx = 7; #1;
        check(rda_ready && rda_value == 0, "R1", rda_value, 0);
        check(rdb_ready && rdb_value == 0, "R1", rdb_value, 0);
    endtask

    task automatic t_load_read();
        load(0, 1);
        load(1, 2);
        rda_idx = 0; rdb_idx = 1; #1;
        expect_a("R2", 1, 1, 0);
        check(rdb_ready && rdb_value == 2, "R10", rdb_value, 2);
        rda_idx = 5; #1;
        expect_a("R3", 1, 0, 0);
    endtask

    task automatic t_rename();
        iss_we = 1; iss_dst = 2; iss_tag = 4;
        tick();
        rda_idx = 2; #1;
        expect_a("R4", 0, 0, 4);
        iss_we = 1; iss_dst = 2; iss_tag = 1;
        tick();
        #1;
        expect_a("R4", 0, 0, 1);
    endtask

    task automatic t_waw();
        bus_valid = 1; bus_tag = 4; bus_data = 99;
        #1;
        expect_a("R6", 0, 0, 1);
        tick();
        rda_idx = 2; #1;
        expect_a("R6", 0, 0, 1);
        bus_valid = 1; bus_tag = 1; bus_data = 55;
        tick();
        #1;
        expect_a("R5", 1, 55, 0);
    endtask

    task automatic t_forward();
        iss_we = 1; iss_dst = 3; iss_tag = 2;
        tick();
        rda_idx = 3; rdb_idx = 0;
        bus_valid = 1; bus_tag = 2; bus_data = 77;
        #1;
        expect_a("R7", 1, 77, 0);
        check(rdb_ready && rdb_value == 1, "R10", rdb_value, 1);
        tick();
        #1;
        expect_a("R5", 1, 77, 0);
    endtask

    task automatic t_collide();
        iss_we = 1; iss_dst = 4; iss_tag = 5;
        tick();
        iss_we = 1; iss_dst = 4; iss_tag = 6;
        bus_valid = 1; bus_tag = 5; bus_data = 33;
        tick();
        rda_idx = 4; #1;
        expect_a("R8", 0, 33, 6);
        bus_valid = 1; bus_tag = 6; bus_data = 44;
        tick();
        #1;
        expect_a("R8", 1, 44, 0);
    endtask

    task automatic t_read_renamed();
        rda_idx = 1;
        iss_we = 1; iss_dst = 1; iss_tag = 7;
        #1;
        expect_a("R9", 1, 2, 0);
        tick();
        #1;
        expect_a("R9", 0, 2, 7);
        load(1, 9);
        #1;
        expect_a("R2", 1, 9, 0);
    endtask

    initial begin
        rst = 1; ld_we = 0; iss_we = 0; bus_valid = 0;
        ld_idx = 0; ld_data = 0; iss_dst = 0; iss_tag = 0;
        bus_tag = 0; bus_data = 0; rda_idx = 0; rdb_idx = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        t_reset();
        t_load_read();
        t_rename();
        t_waw();
        t_forward();
        t_collide();
        t_read_renamed();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule